// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the low-order address bits for a short memory burst. When a burst opens, it captures the low bits of the address supplied from outside. On each later advance it moves to the next address inside the aligned group of 2^BEAT_W locations. The upper address bits never change during a burst. They, the storage array and the bus control belong to the block that instantiates this one.

Two orderings can be selected while running. In the interleaved order the output is the captured start bits XOR a beat counter. In the linear order the output is the start bits plus the beat counter, taken modulo the group size. Either of two load strobes opens a burst. An active-low advance input steps the beat counter. While advance is high the burst is suspended and the address holds.

Top module: `burst_seq_gen`

## Requirements
- R1: When `load_a` or `load_b` (active high, alone or together) is sampled high at a clock edge with `rst_n` high, `burst_addr` equals `ext_lsb` after that edge. The beat counter restarts at zero.
- R2: With `ilv_mode` = 1 the output is start XOR beat. For BEAT_W = 2 the starts 00, 01, 10 and 11 give the orders 00-01-10-11, 01-00-11-10, 10-11-00-01 and 11-10-01-00.
- R3: With `ilv_mode` = 0, each advance adds one to the output modulo 2^BEAT_W.
- R4: An edge with `adv_n` = 1 and no load keeps the start bits and the beat counter, so `burst_addr` does not change while the mode is unchanged.
- R5: After 2^BEAT_W advances the output returns to the start address. Stepping continues with no stop and no error.
- R6: A load takes priority over an advance that falls on the same edge.
- R7: A clock edge with `rst_n` = 0 clears the start bits and the beat counter to zero, so `burst_addr` = 0. Reset takes priority over a load.
- R8: A change on `ilv_mode` changes `burst_addr` in the same cycle, with no clock edge. The burst position is kept.
- R9: BEAT_W sets the group size. With BEAT_W = 3, a linear burst covers all eight addresses and then wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_a | input | 1 | First burst-start strobe, active high |
| load_b | input | 1 | Second burst-start strobe, active high |
| adv_n | input | 1 | Advance to next beat, active low |
| ilv_mode | input | 1 | 1 = interleaved order, 0 = linear order |
| ext_lsb | input | BEAT_W | Low address bits captured at a load |
| burst_addr | output | BEAT_W | Current low address bits of the burst |

## Verification
The bench builds one instance with BEAT_W = 2, the width used in practice. It drives that instance from a vector table that covers every interleaved start pattern, a linear wrap, and mode switches in the middle of a burst. A second instance built with BEAT_W = 3 brings an eight-beat group within reach. That instance shows that the XOR and modulo-add paths and the counter wrap scale with the parameter and are not tied to two bits.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
    // Operation applied to the sequencer state at the next clock edge
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } seq_op_e;
endpackage

// File: rtl/bsg_op_dec.sv
module bsg_op_dec
    import bsg_pkg::*;
(
    input  logic    rst_n,
    input  logic    load_a,
    input  logic    load_b,
    input  logic    adv_n,
    output seq_op_e op
);
    // Priority: reset, then load, then advance, else hold
    always_comb begin
        if (!rst_n)                op = OP_CLEAR;
        else if (load_a || load_b) op = OP_LOAD;
        else if (!adv_n)           op = OP_STEP;
        else                       op = OP_HOLD;
    end
endmodule

// File: rtl/bsg_seq_regs.sv
module bsg_seq_regs
    import bsg_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_op_e           op,
    input  logic [BEAT_W-1:0] ext_lsb,
    output logic [BEAT_W-1:0] start_q,
    output logic [BEAT_W-1:0] beat_q
);
    localparam logic [BEAT_W-1:0] BEAT_LAST = {BEAT_W{1'b1}};

    typedef struct packed {
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] beat;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_CLEAR: begin
                st_d.start = '0;
                st_d.beat  = '0;
            end
            OP_LOAD: begin
                st_d.start = ext_lsb;
                st_d.beat  = '0;
            end
            OP_STEP:  st_d.beat = st_q.beat + 1'b1;
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign start_q = st_q.start;
    assign beat_q  = st_q.beat;

    // R4
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> ($stable(beat_q) && $stable(start_q)));

    // R5
    beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP && beat_q == BEAT_LAST) |=> (beat_q == '0));
endmodule

// File: rtl/bsg_addr_map.sv
module bsg_addr_map #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_q,
    input  logic [BEAT_W-1:0] beat_q,
    input  logic              ilv_mode,
    output logic [BEAT_W-1:0] addr
);
    logic [BEAT_W-1:0] ilv_addr;
    logic [BEAT_W-1:0] lin_addr;

    // Per-bit XOR for interleaved order
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_addr[b] = start_q[b] ^ beat_q[b];
    end

    // Modulo add within the aligned group for linear order
    assign lin_addr = start_q + beat_q;

    always_comb begin
        addr = ilv_mode ? ilv_addr : lin_addr;
    end
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
    import bsg_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_a,
    input  logic              load_b,
    input  logic              adv_n,
    input  logic              ilv_mode,
    input  logic [BEAT_W-1:0] ext_lsb,
    output logic [BEAT_W-1:0] burst_addr
);
    seq_op_e           op;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_q;

    bsg_op_dec u_dec (
        .rst_n  (rst_n),
        .load_a (load_a),
        .load_b (load_b),
        .adv_n  (adv_n),
        .op     (op)
    );

    bsg_seq_regs #(.BEAT_W(BEAT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .ext_lsb (ext_lsb),
        .start_q (start_q),
        .beat_q  (beat_q)
    );

    bsg_addr_map #(.BEAT_W(BEAT_W)) u_map (
        .start_q  (start_q),
        .beat_q   (beat_q),
        .ilv_mode (ilv_mode),
        .addr     (burst_addr)
    );

    // R1 (and R6: a load wins over a simultaneous advance)
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_a || load_b) |=> (burst_addr == $past(ext_lsb)));

    // R3
    lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_a && !load_b && !adv_n && !ilv_mode) ##1 !ilv_mode
        |-> (burst_addr == BEAT_W'($past(burst_addr) + 1'b1)));

    // R2
    ilv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_a && !load_b && !adv_n && ilv_mode) ##1 ilv_mode
        |-> (burst_addr[0] != $past(burst_addr[0])));
endmodule

// File: tb/burst_seq_gen_tb_top.sv
module burst_seq_gen_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, load_a, load_b, adv_n, ilv_mode;
    logic [1:0] ext_lsb, burst_addr;
    logic [2:0] ext3, addr3;
    int checks = 0;
    int errors = 0;

    burst_seq_gen #(.BEAT_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_a(load_a), .load_b(load_b),
        .adv_n(adv_n), .ilv_mode(ilv_mode), .ext_lsb(ext_lsb),
        .burst_addr(burst_addr)
    );

    burst_seq_gen #(.BEAT_W(3)) dut8_i (
        .clk(clk), .rst_n(rst_n), .load_a(load_a), .load_b(load_b),
        .adv_n(adv_n), .ilv_mode(ilv_mode), .ext_lsb(ext3),
        .burst_addr(addr3)
    );

    // {load_a, load_b, adv_n, ilv_mode, ext_lsb[1:0], expected[1:0]}
    localparam int NV = 20;
    localparam logic [7:0] VEC [NV] = '{
        8'b1011_0101, // R1 load_a start 01, interleaved
        8'b0001_0000, // R2 01^1
        8'b0001_0011, // R2 01^2
        8'b0001_0010, // R2 01^3
        8'b0001_0001, // R5 wrap to start
        8'b0011_0001, // R4 suspend
        8'b0110_1010, // R1 load_b start 10, linear
        8'b0000_0011, // R3
        8'b0000_0000, // R3 wrap in group
        8'b0010_0000, // R4 suspend
        8'b0000_0001, // R3
        8'b0000_0010, // R5 back to start
        8'b1000_1111, // R6 load with advance
        8'b0001_0010, // R2 11^1
        8'b0010_0000, // R8 switch to linear: 11+1
        8'b0011_0010, // R8 switch back: 11^1
        8'b1111_0000, // R1 both strobes, start 00
        8'b0001_0001, // R2
        8'b0001_0010, // R2
        8'b0001_0011  // R2
    };

    function automatic string vec_req(int i);
        case (i)
            0, 6, 16:            return "R1";
            4, 11:               return "R5";
            5, 9:                return "R4";
            7, 8, 10:            return "R3";
            12:                  return "R6";
            14, 15:              return "R8";
            default:             return "R2";
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; load_a = 1'b0; load_b = 1'b0; adv_n = 1'b1;
        ilv_mode = 1'b1; ext_lsb = 2'd0; ext3 = 3'd0;
        repeat (3) @(negedge clk);
        chk("R7 reset state", int'(burst_addr), 0);
        chk("R7 reset state w3", int'(addr3), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            load_a   = VEC[i][7];
            load_b   = VEC[i][6];
            adv_n    = VEC[i][5];
            ilv_mode = VEC[i][4];
            ext_lsb  = VEC[i][3:2];
            @(negedge clk);
            chk(vec_req(i), int'(burst_addr), int'(VEC[i][1:0]));
        end

        // R7: reset beats a simultaneous load, and clears the beat counter
        load_a = 1'b1; ext_lsb = 2'd3; rst_n = 1'b0; adv_n = 1'b0;
        @(negedge clk);
        chk("R7 reset over load", int'(burst_addr), 0);
        load_a = 1'b0; rst_n = 1'b1; ilv_mode = 1'b0;
        @(negedge clk);
        chk("R7 beat cleared", int'(burst_addr), 1);

        // R9: eight-beat group, linear from 5
        load_a = 1'b1; adv_n = 1'b1; ext3 = 3'd5;
        @(negedge clk);
        chk("R9 load w3", int'(addr3), 5);
        load_a = 1'b0; adv_n = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            chk("R9 linear w3", int'(addr3), (5 + k) % 8);
        end

        // R9: eight-beat group, interleaved from 5
        load_b = 1'b1; adv_n = 1'b1; ilv_mode = 1'b1;
        @(negedge clk);
        chk("R9 reload w3", int'(addr3), 5);
        load_b = 1'b0; adv_n = 1'b0;
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            chk("R9 interleaved w3", int'(addr3), 5 ^ k);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule